// File: doc/BRIEF.md
# Serial Flash Programming Sequencer

This block is the host side of an in-system programming session for a small microcontroller. The target is reached over a four-byte serial instruction link. The block drives the target's reset line, the serial clock and the host-to-target data line, and it samples the target-to-host data line. It brings the target into programming mode with a reset pulse and a settling delay. It then sends the enable instruction and checks whether the target echoes the synchronisation byte. If the echo is missing, it pulses reset and tries again, up to a fixed number of attempts.

Once the target is in sync, the sequencer takes program words from a ready/valid input, one page at a time. It loads each word into the target's page buffer as two byte instructions, low byte first. It commits each page with a write instruction that carries the page's start address. After the commit it waits a fixed minimum flash write time before the next instruction. On an already erased chip it can skip words equal to 0xFFFF. In verify mode it reads back every word of the page after the write delay and records the first address that differs. At the end of the session it drives reset high, which lets the target run.

Timing is set by parameters: system clocks per millisecond, the settling delay and the write delay in milliseconds, the half period of the serial clock, and the width of the reset pulse.

Top module: `serprog_host`

## Requirements
- R1: While `rst_n` is low, and after it until `start`, `tgt_reset`, `tgt_sck`, `tgt_mosi`, `busy`, `done` and `wd_ready` are all 0.
- R2: On `start`, `tgt_reset` and `tgt_sck` are low first. `tgt_reset` then goes high for exactly RST_CLKS clocks. `tgt_sck` stays low whenever `tgt_reset` is high.
- R3: After every reset pulse, at least PWR_MS*CLK_PER_MS clocks pass between the falling edge of `tgt_reset` and the first rising edge of `tgt_sck`.
- R4: Every instruction is 32 bits, sent MSB first. `tgt_mosi` changes only while `tgt_sck` is low, and `tgt_sck` is high for HALF_CLKS clocks per bit. The enable instruction is 0xAC530000.
- R5: `tgt_miso` is sampled on each rising edge of `tgt_sck`. Enable succeeds when bits 15..8 of the returned frame (the third byte) equal 0x53. Otherwise `tries` increments, a new reset pulse and settling delay follow, and enable is sent again.
- R6: After MAX_TRIES failed enables, `fail_sync` and `done` are set, `tries` equals MAX_TRIES, and no further instruction is sent.
- R7: Each accepted word with index i in the page and word address a = page*PAGE_WORDS+i produces two load frames, {0x40,0x00,a[5:0],low byte} and then {0x48,0x00,a[5:0],high byte}. `wd_ready` is high only while the sequencer waits for a word.
- R8: With `erased`=1, a word equal to 0xFFFF is consumed but produces no load frames. With `erased`=0, it is loaded like any other word.
- R9: After the last word of each page, one write frame {0x4C, page start address (16 bits), 0x00} is sent.
- R10: At least FLASH_MS*CLK_PER_MS clocks pass between the last `tgt_sck` fall of a write frame and the first rise of the next frame.
- R11: With `verify_en`=1, each page is read back after the write delay with frames {0x20,a,0x00} (low byte) and {0x28,a,0x00} (high byte), with the data returned in bits 7..0 of the frame. The first word that differs sets `fail_verify` and latches its address in `bad_addr`.
- R12: When the session ends, `tgt_reset` goes high, `done` is set and `busy` falls. The pages sent are pages 0 to `num_pages`-1, in order.
- R13: With `num_pages`=0, the session sends only the enable instruction(s) and then releases the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a session (sampled while idle) |
| verify_en | input | 1 | Read back each page after writing |
| erased | input | 1 | Target is erased; skip 0xFFFF words |
| num_pages | input | 7 | Number of pages to program |
| wd_valid | input | 1 | Program word available |
| wd_data | input | 16 | Program word |
| wd_ready | output | 1 | Word accepted this cycle when valid |
| tgt_reset | output | 1 | Target reset line |
| tgt_sck | output | 1 | Serial clock to target |
| tgt_mosi | output | 1 | Serial data to target |
| tgt_miso | input | 1 | Serial data from target |
| busy | output | 1 | Session in progress |
| done | output | 1 | Session finished (held until next start) |
| fail_sync | output | 1 | Enable never echoed |
| fail_verify | output | 1 | Readback mismatch seen |
| bad_addr | output | 16 | Word address of the first mismatch |
| tries | output | 4 | Failed enable attempts |

## Verification
The bench targets the retry path. It runs sessions whose enable fails once or twice and sessions where it fails more often than allowed. A sequencer with an off-by-one in the retry limit would send one enable frame too many or too few, or stop with a wrong `tries` value.

Erased pages full of 0xFFFF and non-erased pages holding 0xFFFF words check the skip rule. Skipping in the wrong mode changes the number of load frames.

A target model that corrupts one committed word checks that `bad_addr` names that word. The model also times the gap after each reset fall and after each write frame, so a sequencer that starts an instruction early is caught.

A session with zero pages checks that the target is released straight after the enable.

// File: rtl/serprog_host.sv
module serprog_host #(
  parameter int CLK_PER_MS = 1000,
  parameter int PWR_MS     = 20,
  parameter int FLASH_MS   = 5,
  parameter int HALF_CLKS  = 4,
  parameter int RST_CLKS   = 4,
  parameter int MAX_TRIES  = 3,
  parameter int PAGE_WORDS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        verify_en,
  input  logic        erased,
  input  logic [6:0]  num_pages,
  input  logic        wd_valid,
  input  logic [15:0] wd_data,
  output logic        wd_ready,
  output logic        tgt_reset,
  output logic        tgt_sck,
  output logic        tgt_mosi,
  input  logic        tgt_miso,
  output logic        busy,
  output logic        done,
  output logic        fail_sync,
  output logic        fail_verify,
  output logic [15:0] bad_addr,
  output logic [3:0]  tries
);
  localparam int IW         = $clog2(PAGE_WORDS);
  localparam int PWR_CLKS   = PWR_MS * CLK_PER_MS;
  localparam int FLASH_CLKS = FLASH_MS * CLK_PER_MS;

  typedef enum logic [2:0] {S_IDLE, S_RST, S_PWR, S_XFER, S_GET, S_WAIT, S_END} st_t;
  typedef enum logic [2:0] {OP_EN, OP_LDL, OP_LDH, OP_WR, OP_RDL, OP_RDH} op_t;

  st_t         st;
  op_t         op;
  logic [31:0] tx;
  logic [15:0] rx;
  logic [15:0] hc;
  logic [4:0]  bc;
  logic [31:0] tmr;
  logic        sck_q, rst_q;
  logic [IW-1:0] idx;
  logic [6:0]  page, np_q;
  logic [15:0] pbuf [PAGE_WORDS];
  logic [7:0]  rdlo;
  logic        ver_q, ers_q;

  function automatic logic [31:0] mkframe(op_t o, logic [15:0] a, logic [15:0] d);
    case (o)
      OP_EN:   mkframe = 32'hAC53_0000;
      OP_LDL:  mkframe = {8'h40, 8'h00, 2'b00, a[5:0], d[7:0]};
      OP_LDH:  mkframe = {8'h48, 8'h00, 2'b00, a[5:0], d[15:8]};
      OP_WR:   mkframe = {8'h4C, a, 8'h00};
      OP_RDL:  mkframe = {8'h20, a, 8'h00};
      default: mkframe = {8'h28, a, 8'h00};
    endcase
  endfunction

  wire [15:0] waddr  = 16'({page, idx});
  wire [15:0] pgaddr = 16'({page, {IW{1'b0}}});
  wire [15:0] naddr  = 16'({page, idx + IW'(1)});
  wire        last   = (idx == IW'(PAGE_WORDS - 1));
  wire        lastpg = (page == np_q - 7'd1);
  wire        tick   = (hc == 16'(HALF_CLKS - 1));
  wire        skip   = ers_q && (wd_data == 16'hFFFF);
  wire [15:0] rdword = {rx[7:0], rdlo};

  assign wd_ready  = (st == S_GET);
  assign tgt_reset = rst_q;
  assign tgt_sck   = sck_q;
  assign tgt_mosi  = (st == S_XFER) && tx[31];
  assign busy      = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op <= OP_EN; tx <= '0; rx <= '0; hc <= '0; bc <= '0; tmr <= '0;
      sck_q <= 1'b0; rst_q <= 1'b0; idx <= '0; page <= '0; np_q <= '0; rdlo <= '0;
      ver_q <= 1'b0; ers_q <= 1'b0; done <= 1'b0; fail_sync <= 1'b0;
      fail_verify <= 1'b0; bad_addr <= '0; tries <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          done <= 1'b0; fail_sync <= 1'b0; fail_verify <= 1'b0; bad_addr <= '0; tries <= '0;
          ver_q <= verify_en; ers_q <= erased; np_q <= num_pages;
          rst_q <= 1'b0; sck_q <= 1'b0; tmr <= '0; st <= S_RST;
        end
        S_RST: begin
          tmr <= tmr + 32'd1;
          if (tmr == 32'(HALF_CLKS - 1)) rst_q <= 1'b1;
          if (tmr == 32'(HALF_CLKS + RST_CLKS - 1)) begin
            rst_q <= 1'b0; tmr <= '0; st <= S_PWR;
          end
        end
        S_PWR: begin
          tmr <= tmr + 32'd1;
          if (tmr == 32'(PWR_CLKS - 1)) begin
            tmr <= '0; op <= OP_EN; tx <= mkframe(OP_EN, 16'h0, 16'h0);
            hc <= '0; bc <= '0; st <= S_XFER;
          end
        end
        S_XFER: begin
          if (!tick) hc <= hc + 16'd1;
          else begin
            hc <= '0;
            if (!sck_q) begin
              sck_q <= 1'b1;
              rx <= {rx[14:0], tgt_miso};
            end else begin
              sck_q <= 1'b0;
              tx <= {tx[30:0], 1'b0};
              bc <= bc + 5'd1;
              if (bc == 5'd31) begin
                case (op)
                  OP_EN: begin
                    if (rx[15:8] == 8'h53) begin
                      idx <= '0; page <= '0;
                      st <= (np_q == 7'd0) ? S_END : S_GET;
                    end else begin
                      tries <= tries + 4'd1;
                      tmr <= '0;
                      if (tries == 4'(MAX_TRIES - 1)) begin
                        fail_sync <= 1'b1; st <= S_END;
                      end else st <= S_RST;
                    end
                  end
                  OP_LDL: begin
                    op <= OP_LDH; tx <= mkframe(OP_LDH, waddr, pbuf[idx]);
                  end
                  OP_LDH: begin
                    if (last) begin
                      op <= OP_WR; tx <= mkframe(OP_WR, pgaddr, 16'h0);
                    end else begin
                      idx <= idx + IW'(1); st <= S_GET;
                    end
                  end
                  OP_WR: begin
                    tmr <= '0; st <= S_WAIT;
                  end
                  OP_RDL: begin
                    rdlo <= rx[7:0];
                    op <= OP_RDH; tx <= mkframe(OP_RDH, waddr, 16'h0);
                  end
                  default: begin
                    if (rdword != pbuf[idx] && !fail_verify) begin
                      fail_verify <= 1'b1; bad_addr <= waddr;
                    end
                    if (!last) begin
                      idx <= idx + IW'(1);
                      op <= OP_RDL; tx <= mkframe(OP_RDL, naddr, 16'h0);
                    end else if (lastpg) st <= S_END;
                    else begin
                      page <= page + 7'd1; idx <= '0; st <= S_GET;
                    end
                  end
                endcase
              end
            end
          end
        end
        S_GET: if (wd_valid) begin
          pbuf[idx] <= wd_data;
          hc <= '0; bc <= '0;
          if (!skip) begin
            op <= OP_LDL; tx <= mkframe(OP_LDL, waddr, wd_data); st <= S_XFER;
          end else if (last) begin
            op <= OP_WR; tx <= mkframe(OP_WR, pgaddr, 16'h0); st <= S_XFER;
          end else idx <= idx + IW'(1);
        end
        S_WAIT: begin
          tmr <= tmr + 32'd1;
          if (tmr == 32'(FLASH_CLKS - 1)) begin
            tmr <= '0; hc <= '0; bc <= '0;
            if (ver_q) begin
              idx <= '0; op <= OP_RDL; tx <= mkframe(OP_RDL, pgaddr, 16'h0); st <= S_XFER;
            end else if (lastpg) st <= S_END;
            else begin
              page <= page + 7'd1; idx <= '0; st <= S_GET;
            end
          end
        end
        S_END: begin
          rst_q <= 1'b1; done <= 1'b1; st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serprog_host_chk.sv
module serprog_host_chk #(
  parameter int MAX_TRIES = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tgt_reset,
  input logic       tgt_sck,
  input logic       tgt_mosi,
  input logic       wd_ready,
  input logic       busy,
  input logic       done,
  input logic       fail_sync,
  input logic       fail_verify,
  input logic [3:0] tries
);
  assert_sck_low_in_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_reset |-> !tgt_sck);

  assert_mosi_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_sck && $past(tgt_sck)) |-> $stable(tgt_mosi));

  assert_tries_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tries <= 4'(MAX_TRIES));

  assert_sync_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fail_sync |-> (tries == 4'(MAX_TRIES)));

  assert_feed_only_in_session_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wd_ready |-> (busy && !tgt_reset && !tgt_sck));

  assert_one_failure_kind_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(fail_sync && fail_verify));

  assert_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (tgt_reset && !busy));
endmodule

bind serprog_host serprog_host_chk #(.MAX_TRIES(MAX_TRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .tgt_reset(tgt_reset), .tgt_sck(tgt_sck),
  .tgt_mosi(tgt_mosi), .wd_ready(wd_ready), .busy(busy), .done(done),
  .fail_sync(fail_sync), .fail_verify(fail_verify), .tries(tries)
);

// File: tb/test_serprog_host.sv
module test_serprog_host;
  localparam int CPM = 20, PWRM = 20, FLM = 5, HALF = 2, RSTC = 3, MAXT = 3, PW = 4;
  localparam int PWR_CLKS = PWRM * CPM, FL_CLKS = FLM * CPM;

  logic clk = 0, rst_n = 0, start = 0, verify_en = 0, erased = 0;
  logic [6:0] num_pages = 0;
  logic wd_valid, wd_ready, tgt_reset, tgt_sck, tgt_mosi, busy, done, fail_sync, fail_verify;
  logic tgt_miso = 0;
  logic [15:0] wd_data, bad_addr;
  logic [3:0] tries;

  always #4 clk = ~clk;

  serprog_host #(.CLK_PER_MS(CPM), .PWR_MS(PWRM), .FLASH_MS(FLM), .HALF_CLKS(HALF),
                 .RST_CLKS(RSTC), .MAX_TRIES(MAXT), .PAGE_WORDS(PW)) i_serprog_host (
    .clk(clk), .rst_n(rst_n), .start(start), .verify_en(verify_en), .erased(erased),
    .num_pages(num_pages), .wd_valid(wd_valid), .wd_data(wd_data), .wd_ready(wd_ready),
    .tgt_reset(tgt_reset), .tgt_sck(tgt_sck), .tgt_mosi(tgt_mosi), .tgt_miso(tgt_miso),
    .busy(busy), .done(done), .fail_sync(fail_sync), .fail_verify(fail_verify),
    .bad_addr(bad_addr), .tries(tries));

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic [15:0] words [0:63];
  int wi = 0, total = 0;
  bit feed = 0;

  always @(posedge clk) cyc++;
  assign wd_valid = feed && (wi < total);
  assign wd_data  = words[wi[5:0]];
  always @(posedge clk) begin
    if (start) wi <= 0;
    else if (wd_valid && wd_ready) wi <= wi + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  // target model
  logic [15:0] fl [0:511];
  logic [15:0] pb [0:PW-1];
  bit ld [0:PW-1];
  logic [31:0] sh = 0, r;
  logic [7:0] b1 = 0, b2 = 0, b3 = 0;
  logic [31:0] log_f [0:255];
  int nlog = 0, n = 0, fail_left = 0, caddr = -1;
  int rise_c = 0, rst_rise = 0, rst_fall = 0, wr_end = 0, hi_start = 0;
  bit sync_bad = 0, wr_pend = 0, pwr_chk = 0, rise_pulse = 0, psck = 0, prst = 0;
  int bad_hi = 0, sck_rst = 0, bad_pulse = 0, bad_gap_pwr = 0, bad_gap_wr = 0, n_pulse = 0;

  always @(negedge clk) begin
    if (tgt_reset && tgt_sck) sck_rst++;
    if (tgt_reset && !prst) begin rst_rise = cyc; rise_pulse = !done; end
    if (!tgt_reset && prst && rise_pulse) begin
      n_pulse++;
      if (cyc - rst_rise != RSTC) bad_pulse++;
      rst_fall = cyc; pwr_chk = 1;
    end
    if (tgt_reset) n = 0;
    else begin
      if (tgt_sck && !psck) begin
        hi_start = cyc;
        if (n == 0) begin
          if (pwr_chk) begin if (cyc - rst_fall < PWR_CLKS) bad_gap_pwr++; pwr_chk = 0; end
          if (wr_pend) begin if (cyc - wr_end < FL_CLKS) bad_gap_wr++; wr_pend = 0; end
        end
        sh = {sh[30:0], tgt_mosi}; n++;
        if (n == 8) begin b1 = sh[7:0]; if (b1 == 8'hAC) sync_bad = (fail_left > 0); end
        if (n == 16) b2 = sh[7:0];
        if (n == 24) b3 = sh[7:0];
      end
      if (!tgt_sck && psck) begin
        if (cyc - hi_start != HALF) bad_hi++;
        if (n == 32) begin
          log_f[nlog[7:0]] = sh; nlog++;
          case (b1)
            8'hAC: if (sync_bad) fail_left--;
            8'h40: begin pb[b3[1:0]][7:0] = sh[7:0]; ld[b3[1:0]] = 1; end
            8'h48: begin pb[b3[1:0]][15:8] = sh[7:0]; ld[b3[1:0]] = 1; end
            8'h4C: begin
              for (int i = 0; i < PW; i++) begin
                if (ld[i]) fl[{b2[0], b3} + 9'(i)] = pb[i] ^ ((int'({b2[0], b3}) + i == caddr) ? 16'h1 : 16'h0);
                pb[i] = 16'hFFFF; ld[i] = 0;
              end
              wr_end = cyc; wr_pend = 1;
            end
            default: ;
          endcase
          n = 0;
        end
        r = 0;
        if (n >= 16 && b1 == 8'hAC && !sync_bad) r[15:8] = b2;
        if (n >= 24 && b1 == 8'h20) r[7:0] = fl[{b2[0], b3}][7:0];
        if (n >= 24 && b1 == 8'h28) r[7:0] = fl[{b2[0], b3}][15:8];
        tgt_miso = (n < 32) ? r[31 - n] : 1'b0;
      end
    end
    psck = tgt_sck; prst = tgt_reset;
  end

  logic [31:0] exp_f [0:255];
  int nexp;
  task automatic push(input logic [31:0] f); exp_f[nexp[7:0]] = f; nexp++; endtask

  function automatic string tagof(input logic [7:0] o);
    case (o)
      8'hAC: tagof = "R5 enable frame";
      8'h40, 8'h48: tagof = "R7 load frame";
      8'h4C: tagof = "R9 write frame";
      default: tagof = "R11 read frame";
    endcase
  endfunction

  task automatic run(input int np, input bit er, input bit vf, input int nfail, input int cad);
    int nen, nld_exp, nld_got;
    bit vbad;
    logic [15:0] a, w;
    for (int k = 0; k < 512; k++) fl[k] = 16'hFFFF;
    for (int k = 0; k < PW; k++) begin pb[k] = 16'hFFFF; ld[k] = 0; end
    fail_left = nfail; caddr = cad; nlog = 0; wr_pend = 0; pwr_chk = 0;
    bad_hi = 0; sck_rst = 0; bad_pulse = 0; bad_gap_pwr = 0; bad_gap_wr = 0; n_pulse = 0;
    total = np * PW; feed = 1;
    @(negedge clk);
    start = 1; num_pages = 7'(np); erased = er; verify_en = vf;
    @(negedge clk);
    start = 0;
    while (!done) @(negedge clk);
    @(negedge clk);
    feed = 0;
    nexp = 0; nld_exp = 0; nld_got = 0; vbad = 0;
    nen = (nfail < MAXT) ? nfail + 1 : MAXT;
    for (int k = 0; k < nen; k++) push(32'hAC53_0000);
    if (nfail < MAXT)
      for (int p = 0; p < np; p++) begin
        for (int i = 0; i < PW; i++) begin
          a = 16'(p * PW + i); w = words[p * PW + i];
          if (!(er && w == 16'hFFFF)) begin
            push({8'h40, 8'h00, 2'b00, a[5:0], w[7:0]});
            push({8'h48, 8'h00, 2'b00, a[5:0], w[15:8]});
            nld_exp++;
            if (vf && int'(a) == cad) vbad = 1;
          end
        end
        push({8'h4C, 16'(p * PW), 8'h00});
        if (vf)
          for (int i = 0; i < PW; i++) begin
            push({8'h20, 16'(p * PW + i), 8'h00});
            push({8'h28, 16'(p * PW + i), 8'h00});
          end
      end
    chk(nlog == nexp, "R12 frame count", nlog, nexp);
    for (int k = 0; k < nexp && k < nlog; k++) begin
      chk(log_f[k] == exp_f[k], tagof(exp_f[k][31:24]), log_f[k], exp_f[k]);
      if (log_f[k][31:24] == 8'h40) nld_got++;
    end
    chk(nld_got == nld_exp, "R8 loaded word count", nld_got, nld_exp);
    chk(n_pulse == nen, "R2 reset pulse count", n_pulse, nen);
    chk(bad_pulse == 0 && sck_rst == 0, "R2 reset pulse width / sck low", bad_pulse + sck_rst, 0);
    chk(bad_gap_pwr == 0, "R3 settle gap", bad_gap_pwr, 0);
    chk(bad_hi == 0, "R4 sck high width", bad_hi, 0);
    chk(bad_gap_wr == 0, "R10 flash write gap", bad_gap_wr, 0);
    chk(tries == 4'((nfail < MAXT) ? nfail : MAXT), "R5 tries", tries, (nfail < MAXT) ? nfail : MAXT);
    chk(fail_sync == (nfail >= MAXT), "R6 fail_sync", fail_sync, nfail >= MAXT);
    chk(wi == ((nfail < MAXT) ? total : 0), "R7 words consumed", wi, (nfail < MAXT) ? total : 0);
    chk(fail_verify == vbad, "R11 fail_verify", fail_verify, vbad);
    if (vbad) chk(bad_addr == 16'(cad), "R11 bad_addr", bad_addr, cad);
    chk(done && tgt_reset && !busy, "R12 release", {done, tgt_reset, busy}, 3'b110);
    if (np == 0) chk(nlog == nen, "R13 zero pages", nlog, nen);
  endtask

  function automatic logic [15:0] rword();
    rword = ($urandom_range(0, 3) == 0) ? 16'hFFFF : 16'($urandom);
  endfunction

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    void'($urandom(32'd2024));
    for (int k = 0; k < 64; k++) words[k] = rword();
    repeat (4) @(negedge clk);
    chk({tgt_reset, tgt_sck, tgt_mosi, busy, done, wd_ready} == 6'b0, "R1 in reset",
        {tgt_reset, tgt_sck, tgt_mosi, busy, done, wd_ready}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk({tgt_reset, tgt_sck, tgt_mosi, busy, done, wd_ready} == 6'b0, "R1 after reset",
        {tgt_reset, tgt_sck, tgt_mosi, busy, done, wd_ready}, 0);

    words[1] = 16'hFFFF; words[6] = 16'hFFFF;
    run(2, 1, 1, 1, -1);
    words[0] = 16'h1234; words[1] = 16'hFFFF; words[2] = 16'hA55A; words[3] = 16'h0F0F;
    run(1, 0, 1, 0, 2);
    run(1, 1, 0, 5, -1);
    for (int k = 0; k < PW; k++) words[k] = 16'hFFFF;
    run(1, 1, 0, 0, -1);
    run(0, 0, 0, 0, -1);
    words[0] = 16'hBEEF; words[1] = 16'h0001;
    run(1, 0, 0, MAXT - 1, -1);
    for (int t = 0; t < 4; t++) begin
      int np, cad;
      for (int k = 0; k < 64; k++) words[k] = rword();
      np = $urandom_range(1, 3);
      cad = ($urandom_range(0, 1) == 1) ? $urandom_range(0, np * PW - 1) : -1;
      run(np, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), $urandom_range(0, 2), cad);
    end
    report();
  end
endmodule